// File: doc/BRIEF.md
# Word/Doubleword Shift Unit

This block is the shift stage of a 64-bit integer datapath. It is purely combinational. It takes one operand and a shift amount, and produces the shifted value. It supports logical left shifts, logical right shifts and arithmetic right shifts. Each shift can work on a 32-bit word or on a 64-bit doubleword.

The shift amount has two possible sources. The first is a 5-bit immediate taken from the instruction. The second is the low bits of a register operand. Doubleword shifts that use the immediate can also add 32 to it, so the whole range 0 to 63 can be reached from a 5-bit field.

Word shifts use only the lower half of the operand. Their 32-bit result is sign-extended to 64 bits, so word values always sit in canonical form in the 64-bit register file. Decoding the instruction and reading the registers happen outside this block. The block only sees the control fields it needs.

Top module: `shf_unit`

## Requirements
- R1: `op_kind` selects the operation. 2'b00 is a logical left shift, 2'b10 is a logical right shift and 2'b11 is an arithmetic right shift. The code 2'b01 is reserved and gives an all-zero `result`.
- R2: Logical shifts, left or right, fill every vacated bit position with 0.
- R3: Arithmetic right shifts fill every vacated bit position with the sign bit of the operand width being shifted.
- R4: When `amt_from_reg` is 0, the amount comes from `imm_amt`. When it is 1, the amount comes from the low bits of `reg_amt`.
- R5: A word shift uses only bits 4:0 of `reg_amt`. A doubleword shift uses only bits 5:0. Higher bits of `reg_amt` have no effect on `result`.
- R6: When `op_dword`=1, `amt_from_reg`=0 and `op_plus32`=1, the shift amount is `imm_amt` + 32.
- R7: `op_plus32` has no effect on `result` for word shifts or for shifts whose amount comes from a register.
- R8: A word shift (`op_dword`=0) operates on `opnd[31:0]`, and `opnd[63:32]` has no effect. `result[63:32]` always equals 32 copies of `result[31]`.
- R9: For a word arithmetic right shift, the fill bit is `opnd[31]`.
- R10: A shift by 0 returns `opnd` for a doubleword, and `opnd[31:0]` sign-extended for a word.
- R11: `result` depends only on the current inputs. It is valid in the same cycle, with no register or clock in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd | input | 64 | Value to be shifted |
| imm_amt | input | 5 | Shift amount from the instruction field |
| reg_amt | input | 64 | Register operand supplying a variable amount |
| amt_from_reg | input | 1 | 1: amount from reg_amt, 0: from imm_amt |
| op_dword | input | 1 | 1: 64-bit shift, 0: 32-bit word shift |
| op_plus32 | input | 1 | Adds 32 to an immediate doubleword amount |
| op_kind | input | 2 | Operation code (see R1) |
| result | output | 64 | Shifted value |

## Verification
Every amount from 0 to the width limit is swept with three operands:
- An alternating pattern checks that each bit lands in the right position.
- A negative value with only the top bit set separates zero fill from sign fill.
- A value with bit 31 set and junk in the upper half shows whether word shifts ignore the upper half and take their sign from bit 31.

Register amounts carry set high bits, which would show if amount masking were missing. The "+32" flag is applied to word and register forms as well, so that an unwanted offset would show up as a different result. Shifts by zero and by the largest amount mark the edges of the range.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int XLEN = 64;
  localparam int WLEN = 32;

  typedef enum logic [1:0] {
    KIND_SLL  = 2'b00,
    KIND_RSVD = 2'b01,
    KIND_SRL  = 2'b10,
    KIND_SRA  = 2'b11
  } shf_kind_e;

  // Mirror a vector end for end so one right shifter can also shift left.
  function automatic logic [XLEN-1:0] bit_mirror(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = v[XLEN-1-i];
    return r;
  endfunction

  // Copy bit WLEN-1 into every bit above it.
  function automatic logic [XLEN-1:0] word_sext(input logic [WLEN-1:0] w);
    return {{(XLEN-WLEN){w[WLEN-1]}}, w};
  endfunction

  // Mask that covers the lowest n bits.
  function automatic logic [XLEN-1:0] low_mask(input int unsigned n);
    logic [XLEN-1:0] m;
    for (int i = 0; i < XLEN; i++) m[i] = (i < n);
    return m;
  endfunction
endpackage

// File: rtl/shf_amount.sv
module shf_amount #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int AW  = $clog2(XLEN),
  localparam int WAW = $clog2(WLEN)
) (
  input  logic [WAW-1:0]  imm_amt,
  input  logic [XLEN-1:0] reg_amt,
  input  logic            amt_from_reg,
  input  logic            op_dword,
  input  logic            op_plus32,
  output logic [AW-1:0]   eff_amt
);
  logic [AW-1:0] imm_ext;
  logic [AW-1:0] reg_trim;
  logic [AW-1:0] imm_bias;

  always_comb begin
    imm_ext  = AW'(imm_amt);
    imm_bias = (op_dword && op_plus32) ? AW'(WLEN) : '0;
    reg_trim = op_dword ? reg_amt[AW-1:0] : AW'(reg_amt[WAW-1:0]);
    eff_amt  = amt_from_reg ? reg_trim : (imm_ext + imm_bias);
  end

  always_comb begin
    // R5
    word_amt_range_chk: assert (op_dword || (eff_amt < AW'(WLEN)))
      else $error("word shift amount out of range");
    // R6
    plus32_offset_chk: assert (!(op_dword && op_plus32 && !amt_from_reg) || (eff_amt >= AW'(WLEN)))
      else $error("+32 form below 32");
  end
endmodule

// File: rtl/shf_core.sv
module shf_core #(
  parameter int XLEN = 64,
  localparam int AW  = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] din,
  input  logic [AW-1:0]   amt,
  input  logic            go_left,
  input  logic            fill,
  output logic [XLEN-1:0] dout
);
  import shf_pkg::*;

  logic [XLEN-1:0] stage [AW+1];
  logic [XLEN-1:0] pre;

  assign pre      = go_left ? bit_mirror(din) : din;
  assign stage[0] = pre;

  for (genvar i = 0; i < AW; i++) begin : g_stage
    localparam int SH = 1 << i;
    assign stage[i+1] = amt[i] ? {{SH{fill}}, stage[i][XLEN-1:SH]} : stage[i];
  end

  assign dout = go_left ? bit_mirror(stage[AW]) : stage[AW];
endmodule

// File: rtl/shf_wordfix.sv
module shf_wordfix #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] opnd,
  input  logic            is_word,
  input  logic            arith,
  input  logic [XLEN-1:0] core_out,
  output logic [XLEN-1:0] core_in,
  output logic            fill,
  output logic [XLEN-1:0] shaped
);
  import shf_pkg::*;

  logic sign_bit;

  always_comb begin
    sign_bit = is_word ? opnd[WLEN-1] : opnd[XLEN-1];
    fill     = arith & sign_bit;
    if (is_word) core_in = {{(XLEN-WLEN){fill}}, opnd[WLEN-1:0]};
    else         core_in = opnd;
    shaped   = is_word ? word_sext(core_out[WLEN-1:0]) : core_out;
  end
endmodule

// File: rtl/shf_unit.sv
module shf_unit #(
  parameter int XLEN = 64,
  parameter int WLEN = 32,
  localparam int AW  = $clog2(XLEN),
  localparam int WAW = $clog2(WLEN)
) (
  input  logic [XLEN-1:0] opnd,
  input  logic [WAW-1:0]  imm_amt,
  input  logic [XLEN-1:0] reg_amt,
  input  logic            amt_from_reg,
  input  logic            op_dword,
  input  logic            op_plus32,
  input  logic [1:0]      op_kind,
  output logic [XLEN-1:0] result
);
  import shf_pkg::*;

  logic [AW-1:0]   eff_amt;
  logic [XLEN-1:0] core_in;
  logic [XLEN-1:0] core_out;
  logic [XLEN-1:0] shaped;
  logic            fill;
  logic            go_left;
  logic            arith;
  logic            reserved;

  assign go_left  = (op_kind == KIND_SLL);
  assign arith    = (op_kind == KIND_SRA);
  assign reserved = (op_kind == KIND_RSVD);

  shf_amount #(.XLEN(XLEN), .WLEN(WLEN)) u_amt (
    .imm_amt(imm_amt), .reg_amt(reg_amt), .amt_from_reg(amt_from_reg),
    .op_dword(op_dword), .op_plus32(op_plus32), .eff_amt(eff_amt)
  );

  shf_wordfix #(.XLEN(XLEN), .WLEN(WLEN)) u_wfix (
    .opnd(opnd), .is_word(!op_dword), .arith(arith), .core_out(core_out),
    .core_in(core_in), .fill(fill), .shaped(shaped)
  );

  shf_core #(.XLEN(XLEN)) u_core (
    .din(core_in), .amt(eff_amt), .go_left(go_left), .fill(fill), .dout(core_out)
  );

  assign result = reserved ? '0 : shaped;

  always_comb begin
    // R2
    sll_low_zero_chk: assert (!(op_dword && go_left) || ((result & low_mask(eff_amt)) == '0))
      else $error("left shift vacated bits not zero");
    // R2
    srl_top_zero_chk: assert (!(op_dword && op_kind == KIND_SRL && eff_amt != '0) || !result[XLEN-1])
      else $error("logical right shift top bit not zero");
    // R3
    sra_sign_keep_chk: assert (!(op_dword && arith) || (result[XLEN-1] == opnd[XLEN-1]))
      else $error("arithmetic shift lost sign");
    // R8
    word_sext_chk: assert (op_dword || (result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}}))
      else $error("word result not sign-extended");
    // R9
    word_sra_sign_chk: assert (!(!op_dword && arith) || (result[XLEN-1] == opnd[WLEN-1]))
      else $error("word arithmetic sign not from bit 31");
  end
endmodule

// File: tb/shf_unit_test.sv
module shf_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] opnd = '0;
  logic [4:0]  imm_amt = '0;
  logic [63:0] reg_amt = '0;
  logic        amt_from_reg = 0;
  logic        op_dword = 0;
  logic        op_plus32 = 0;
  logic [1:0]  op_kind = 2'b00;
  logic [63:0] result;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shf_unit uut (
    .opnd(opnd), .imm_amt(imm_amt), .reg_amt(reg_amt), .amt_from_reg(amt_from_reg),
    .op_dword(op_dword), .op_plus32(op_plus32), .op_kind(op_kind), .result(result)
  );

  function automatic logic [63:0] model(input logic [63:0] v, input int amt,
                                        input logic dw, input logic [1:0] k);
    logic [31:0] w;
    logic [63:0] r;
    if (k == 2'b01) return 64'd0;
    if (dw) begin
      case (k)
        2'b00:   r = v << amt;
        2'b10:   r = v >> amt;
        default: r = $unsigned($signed(v) >>> amt);
      endcase
      return r;
    end
    case (k)
      2'b00:   w = v[31:0] << amt;
      2'b10:   w = v[31:0] >> amt;
      default: w = $unsigned($signed(v[31:0]) >>> amt);
    endcase
    return {{32{w[31]}}, w};
  endfunction

  task automatic apply(input logic [63:0] v, input logic [4:0] imm, input logic [63:0] ra,
                       input logic src, input logic dw, input logic p32, input logic [1:0] k);
    @(negedge clk);
    opnd = v; imm_amt = imm; reg_amt = ra; amt_from_reg = src;
    op_dword = dw; op_plus32 = p32; op_kind = k;
    #1;
  endtask

  task automatic check(input string req, input logic [63:0] exp);
    n_checks++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (opnd=%h imm=%0d reg=%h src=%0b dw=%0b p32=%0b kind=%b)",
               req, result, exp, opnd, imm_amt, reg_amt, amt_from_reg, op_dword, op_plus32, op_kind);
    end
  endtask

  // R11: all-zero inputs after reset give zero at once
  task automatic t_reset_state();
    apply(64'd0, 5'd0, 64'd0, 0, 0, 0, 2'b00);
    check("R11", 64'd0);
    apply(64'hFFFF_0000_1234_5678, 5'd4, 64'd0, 0, 1, 0, 2'b00);
    check("R11", 64'hFFF0_0001_2345_6780);
  endtask

  // R2 R3 R9 R8: word immediate sweep
  task automatic t_word_imm();
    logic [63:0] pats [3] = '{64'hA5A5_A5A5_5A5A_5A5A, 64'h8000_0000_0000_0000, 64'h1234_5678_8765_4321};
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 32; a++)
        for (int k = 0; k < 4; k++) begin
          if (k == 1) continue;
          apply(pats[p], 5'(a), 64'd0, 0, 0, 0, 2'(k));
          check(k == 3 ? "R9" : "R2", model(pats[p], a, 0, 2'(k)));
        end
  endtask

  // R2 R3 R6: doubleword immediate with and without +32
  task automatic t_dword_imm();
    logic [63:0] pats [3] = '{64'hA5A5_A5A5_5A5A_5A5A, 64'h8000_0000_0000_0000, 64'hF0E1_D2C3_B4A5_9687};
    for (int p = 0; p < 3; p++)
      for (int a = 0; a < 32; a++)
        for (int k = 0; k < 4; k++) begin
          if (k == 1) continue;
          apply(pats[p], 5'(a), 64'd0, 0, 1, 0, 2'(k));
          check(k == 3 ? "R3" : "R2", model(pats[p], a, 1, 2'(k)));
          apply(pats[p], 5'(a), 64'd0, 0, 1, 1, 2'(k));
          check("R6", model(pats[p], a + 32, 1, 2'(k)));
        end
  endtask

  // R4 R5: register amounts with junk in high bits
  task automatic t_reg_amount();
    logic [63:0] v = 64'hC3C3_0F0F_8421_1248;
    for (int a = 0; a < 64; a++)
      for (int k = 0; k < 4; k++) begin
        if (k == 1) continue;
        apply(v, 5'd7, 64'hFFFF_FFFF_FFFF_FFC0 | 64'(a), 1, 1, 0, 2'(k));
        check("R5", model(v, a, 1, 2'(k)));
        apply(v, 5'd7, 64'hABCD_0000_0000_00E0 | 64'(a & 31), 1, 0, 0, 2'(k));
        check("R4", model(v, a & 31, 0, 2'(k)));
      end
  endtask

  // R7: +32 flag ignored for words and register amounts
  task automatic t_plus32_ignored();
    logic [63:0] v = 64'h8765_4321_F00D_BEEF;
    for (int k = 0; k < 4; k++) begin
      if (k == 1) continue;
      apply(v, 5'd5, 64'd0, 0, 0, 1, 2'(k));
      check("R7", model(v, 5, 0, 2'(k)));
      apply(v, 5'd0, 64'd9, 1, 1, 1, 2'(k));
      check("R7", model(v, 9, 1, 2'(k)));
      apply(v, 5'd0, 64'd3, 1, 0, 1, 2'(k));
      check("R7", model(v, 3, 0, 2'(k)));
    end
  endtask

  // R1 R8 R10: reserved code, upper-half independence, zero amount
  task automatic t_edges();
    apply(64'hFFFF_FFFF_FFFF_FFFF, 5'd3, 64'd0, 0, 1, 0, 2'b01);
    check("R1", 64'd0);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 5'd3, 64'd0, 0, 0, 0, 2'b01);
    check("R1", 64'd0);
    apply(64'hDEAD_BEEF_7FFF_FFFF, 5'd0, 64'd0, 0, 0, 0, 2'b10);
    check("R8", 64'h0000_0000_7FFF_FFFF);
    apply(64'h0000_0000_8000_0001, 5'd0, 64'd0, 0, 0, 0, 2'b00);
    check("R10", 64'hFFFF_FFFF_8000_0001);
    apply(64'h8000_0000_0000_0001, 5'd0, 64'd0, 0, 1, 0, 2'b11);
    check("R10", 64'h8000_0000_0000_0001);
    apply(64'h8000_0000_0000_0000, 5'd31, 64'd0, 0, 1, 1, 2'b11);
    check("R3", 64'hFFFF_FFFF_FFFF_FFFF);
    apply(64'h0000_0000_0000_0001, 5'd31, 64'd0, 0, 1, 1, 2'b00);
    check("R2", 64'h8000_0000_0000_0000);
    apply(64'h0000_0000_8000_0000, 5'd31, 64'd0, 0, 0, 0, 2'b11);
    check("R9", 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    t_reset_state();
    t_word_imm();
    t_dword_imm();
    t_reg_amount();
    t_plus32_ignored();
    t_edges();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule